// File: doc/BRIEF.md
# PLL Divider, Phase Detector and Lock Core

This block is the digital heart of a dual-loop frequency synthesizer. Every input arrives as a one-cycle event pulse in the system clock domain. There are three such inputs: the reference (crystal) event and the feedback events of two oscillators. The converter loop is programmable. Its reference path divides by a fixed pre-divider and then by a programmable ratio. Its feedback path divides by a fixed prescaler and then by a 12-bit programmable ratio, so the oscillator runs at prescale times ratio times the comparison rate. The modulator loop is simpler. Its feedback divider is fixed, and a 2-bit code selects its reference divider.

Each loop has a phase/frequency detector that drives up/down correction pulses toward the analog charge pump, and a lock monitor that watches the width of those pulses. The single lock output is the AND of both monitors. A 3-bit setting chooses the converter charge-pump current level. For some setting values the level also follows the live converter lock state, so the loop can acquire fast and then settle quietly.

Top module: `pll_synth_core`

## Requirements
- R1: The converter reference path divides reference events by REF_PREDIV and then by `conv_ref_ratio`. A ratio below CONV_REF_MIN is treated as CONV_REF_MIN, and a ratio above CONV_REF_MAX is treated as CONV_REF_MAX. Each divider stage fires on its N-th input event and emits a one-cycle registered pulse.
- R2: The converter feedback path divides oscillator events by FB_PRESCALE and then by the 12-bit `conv_fb_ratio`. That ratio is clamped to the range CONV_FB_MIN to CONV_FB_MAX.
- R3: The modulator feedback divider has the fixed ratio MOD_FB_RATIO. The modulator reference ratio is set by `mod_ref_sel`: 2'b11 gives 4, 2'b10 gives 8, and both 2'b01 and 2'b00 give 16.
- R4: In each phase/frequency detector, a divided reference pulse sets up and a divided feedback pulse sets down. When both are pending, the two are cleared, so up and down are never high together.
- R5: A loop becomes locked at the 16th (LOCK_PERIODS) consecutive divided-reference pulse during which no up/down pulse has lasted PW_THRESH cycles. It becomes unlocked in the cycle after any pulse reaches PW_THRESH cycles.
- R6: `lock` is high only when both loops are locked. It lags the loop states by one cycle.
- R7: `cp_code` uses the encoding 2'b00 low, 2'b01 medium, 2'b10 high, and is registered one cycle after `cp_setting`. With setting 3'b000 it is high while the converter is unlocked and medium while it is locked.
- R8: With setting 3'b001, `cp_code` is medium while the converter is unlocked and low while it is locked.
- R9: Settings 3'b010, 3'b011 and 3'b100 give low, medium and high whatever the lock state. Settings 3'b101 to 3'b111 give low.
- R10: While `rst` is high, all up/down outputs and `lock` are 0 and `cp_code` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_ev | input | 1 | Reference event pulse |
| conv_vco_ev | input | 1 | Converter oscillator event pulse |
| mod_vco_ev | input | 1 | Modulator oscillator event pulse |
| conv_ref_ratio | input | REF_W | Converter programmable reference ratio |
| conv_fb_ratio | input | FB_W | Converter programmable feedback ratio |
| mod_ref_sel | input | 2 | Modulator reference ratio select |
| cp_setting | input | 3 | Charge-pump current setting |
| conv_up | output | 1 | Converter pump-up pulse |
| conv_dn | output | 1 | Converter pump-down pulse |
| mod_up | output | 1 | Modulator pump-up pulse |
| mod_dn | output | 1 | Modulator pump-down pulse |
| cp_code | output | 2 | Selected charge-pump current level |
| lock | output | 1 | Both loops locked |

## Verification
The bench keeps the fixed pre-divider at 2 and the prescaler at 4, and shrinks the other parameters: a modulator feedback ratio of 20, a reference ratio range of 4 to 16, a feedback ratio range of 10 to 40, and a pulse-width threshold of 6 cycles. With these values, a full acquisition of sixteen comparison periods takes only a few hundred cycles, so the bench can reach lock, loss of lock, clamping at both ends of a range and every reference select code. A behavioural model tracks every divider, detector and monitor cycle by cycle and is compared with all outputs on each clock.

// File: rtl/pll_core_pkg.sv
package pll_core_pkg;

  typedef enum logic [1:0] {
    CP_LOW  = 2'b00,
    CP_MED  = 2'b01,
    CP_HIGH = 2'b10
  } cp_level_e;

  localparam int unsigned MSEL_W = 5;

  // Current level from the programmed setting and the live converter lock
  function automatic cp_level_e cp_pick(input logic [2:0] setting, input logic locked);
    cp_level_e lvl;
    case (setting)
      3'b000:  lvl = locked ? CP_MED : CP_HIGH;
      3'b001:  lvl = locked ? CP_LOW : CP_MED;
      3'b010:  lvl = CP_LOW;
      3'b011:  lvl = CP_MED;
      3'b100:  lvl = CP_HIGH;
      default: lvl = CP_LOW;
    endcase
    return lvl;
  endfunction

  // Modulator reference ratio; the unused code falls back to the largest ratio
  function automatic logic [MSEL_W-1:0] mod_ratio(input logic [1:0] sel);
    logic [MSEL_W-1:0] r;
    case (sel)
      2'b11:   r = MSEL_W'(4);
      2'b10:   r = MSEL_W'(8);
      default: r = MSEL_W'(16);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ratio_divider.sv
module ratio_divider #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ev_in,
  input  logic [W-1:0] ratio,
  output logic         tick_out
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      tick_out <= 1'b0;
    end else begin
      tick_out <= 1'b0;
      if (ev_in) begin
        // a shrinking ratio lands on the terminal test at once
        if (cnt >= ratio - W'(1)) begin
          cnt      <= '0;
          tick_out <= 1'b1;
        end else begin
          cnt <= cnt + W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/phase_freq_det.sv
module phase_freq_det (
  input  logic clk,
  input  logic rst,
  input  logic ref_tick,
  input  logic fb_tick,
  output logic up,
  output logic dn
);

  logic up_pend, dn_pend;

  always_comb begin
    up_pend = up | ref_tick;
    dn_pend = dn | fb_tick;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else begin
      // both pending: the reset path clears the pair in the same cycle
      up <= up_pend & ~dn_pend;
      dn <= dn_pend & ~up_pend;
    end
  end

endmodule

// File: rtl/lock_monitor.sv
module lock_monitor #(
  parameter int unsigned PW_THRESH    = 16,
  parameter int unsigned LOCK_PERIODS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic period_tick,
  input  logic up,
  input  logic dn,
  output logic locked
);

  localparam int unsigned WW = $clog2(PW_THRESH + 1);
  localparam int unsigned GW = $clog2(LOCK_PERIODS + 1);

  logic [WW-1:0] width_cnt;
  logic [GW-1:0] good_cnt;
  logic          bad_period;
  logic          active, too_wide;

  always_comb begin
    active   = up | dn;
    too_wide = active && (width_cnt >= WW'(PW_THRESH - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      width_cnt <= '0;
    end else if (!active) begin
      width_cnt <= '0;
    end else if (width_cnt != WW'(PW_THRESH)) begin
      width_cnt <= width_cnt + WW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      good_cnt   <= '0;
      bad_period <= 1'b0;
      locked     <= 1'b0;
    end else if (too_wide) begin
      good_cnt   <= '0;
      bad_period <= 1'b1;
      locked     <= 1'b0;
    end else if (period_tick) begin
      if (bad_period) begin
        bad_period <= 1'b0;
        good_cnt   <= '0;
      end else if (good_cnt >= GW'(LOCK_PERIODS - 1)) begin
        locked <= 1'b1;
      end else begin
        good_cnt <= good_cnt + GW'(1);
      end
    end
  end

endmodule

// File: rtl/pll_synth_core.sv
module pll_synth_core
  import pll_core_pkg::*;
#(
  parameter int unsigned REF_W        = 8,
  parameter int unsigned FB_W         = 12,
  parameter int unsigned REF_PREDIV   = 2,
  parameter int unsigned FB_PRESCALE  = 4,
  parameter int unsigned MOD_FB_RATIO = 1120,
  parameter int unsigned CONV_REF_MIN = 4,
  parameter int unsigned CONV_REF_MAX = 160,
  parameter int unsigned CONV_FB_MIN  = 290,
  parameter int unsigned CONV_FB_MAX  = 1800,
  parameter int unsigned PW_THRESH    = 16,
  parameter int unsigned LOCK_PERIODS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_ev,
  input  logic             conv_vco_ev,
  input  logic             mod_vco_ev,
  input  logic [REF_W-1:0] conv_ref_ratio,
  input  logic [FB_W-1:0]  conv_fb_ratio,
  input  logic [1:0]       mod_ref_sel,
  input  logic [2:0]       cp_setting,
  output logic             conv_up,
  output logic             conv_dn,
  output logic             mod_up,
  output logic             mod_dn,
  output logic [1:0]       cp_code,
  output logic             lock
);

  localparam int unsigned PRE_W = $clog2(REF_PREDIV + 1);
  localparam int unsigned PS_W  = $clog2(FB_PRESCALE + 1);
  localparam int unsigned MFB_W = $clog2(MOD_FB_RATIO + 1);

  logic             ref_pre, fb_pre;
  logic             conv_fr, conv_fv, mod_fr, mod_fv;
  logic             conv_locked, mod_locked;
  logic [REF_W-1:0] ref_ratio_eff;
  logic [FB_W-1:0]  fb_ratio_eff;
  cp_level_e        cp_q;
  logic             lock_q;

  // Out-of-range ratios snap to the nearest legal limit
  always_comb begin
    if (conv_ref_ratio < REF_W'(CONV_REF_MIN))      ref_ratio_eff = REF_W'(CONV_REF_MIN);
    else if (conv_ref_ratio > REF_W'(CONV_REF_MAX)) ref_ratio_eff = REF_W'(CONV_REF_MAX);
    else                                            ref_ratio_eff = conv_ref_ratio;
    if (conv_fb_ratio < FB_W'(CONV_FB_MIN))         fb_ratio_eff = FB_W'(CONV_FB_MIN);
    else if (conv_fb_ratio > FB_W'(CONV_FB_MAX))    fb_ratio_eff = FB_W'(CONV_FB_MAX);
    else                                            fb_ratio_eff = conv_fb_ratio;
  end

  // Fixed stages: a ratio of one degenerates to a wire
  generate
    if (REF_PREDIV > 1) begin : g_ref_pre
      ratio_divider #(.W(PRE_W)) u_div (
        .clk(clk), .rst(rst), .ev_in(ref_ev),
        .ratio(PRE_W'(REF_PREDIV)), .tick_out(ref_pre)
      );
    end else begin : g_ref_wire
      assign ref_pre = ref_ev;
    end
    if (FB_PRESCALE > 1) begin : g_fb_pre
      ratio_divider #(.W(PS_W)) u_div (
        .clk(clk), .rst(rst), .ev_in(conv_vco_ev),
        .ratio(PS_W'(FB_PRESCALE)), .tick_out(fb_pre)
      );
    end else begin : g_fb_wire
      assign fb_pre = conv_vco_ev;
    end
  endgenerate

  ratio_divider #(.W(REF_W)) u_conv_ref (
    .clk(clk), .rst(rst), .ev_in(ref_pre),
    .ratio(ref_ratio_eff), .tick_out(conv_fr)
  );

  ratio_divider #(.W(FB_W)) u_conv_fb (
    .clk(clk), .rst(rst), .ev_in(fb_pre),
    .ratio(fb_ratio_eff), .tick_out(conv_fv)
  );

  ratio_divider #(.W(MSEL_W)) u_mod_ref (
    .clk(clk), .rst(rst), .ev_in(ref_ev),
    .ratio(mod_ratio(mod_ref_sel)), .tick_out(mod_fr)
  );

  ratio_divider #(.W(MFB_W)) u_mod_fb (
    .clk(clk), .rst(rst), .ev_in(mod_vco_ev),
    .ratio(MFB_W'(MOD_FB_RATIO)), .tick_out(mod_fv)
  );

  phase_freq_det u_conv_pfd (
    .clk(clk), .rst(rst), .ref_tick(conv_fr), .fb_tick(conv_fv),
    .up(conv_up), .dn(conv_dn)
  );

  phase_freq_det u_mod_pfd (
    .clk(clk), .rst(rst), .ref_tick(mod_fr), .fb_tick(mod_fv),
    .up(mod_up), .dn(mod_dn)
  );

  lock_monitor #(.PW_THRESH(PW_THRESH), .LOCK_PERIODS(LOCK_PERIODS)) u_conv_lock (
    .clk(clk), .rst(rst), .period_tick(conv_fr),
    .up(conv_up), .dn(conv_dn), .locked(conv_locked)
  );

  lock_monitor #(.PW_THRESH(PW_THRESH), .LOCK_PERIODS(LOCK_PERIODS)) u_mod_lock (
    .clk(clk), .rst(rst), .period_tick(mod_fr),
    .up(mod_up), .dn(mod_dn), .locked(mod_locked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cp_q   <= CP_LOW;
      lock_q <= 1'b0;
    end else begin
      cp_q   <= cp_pick(cp_setting, conv_locked);
      lock_q <= conv_locked & mod_locked;
    end
  end

  assign cp_code = cp_q;
  assign lock    = lock_q;

endmodule

// File: rtl/pll_synth_core_chk.sv
module pll_synth_core_chk (
  input logic       clk,
  input logic       rst,
  input logic       conv_up,
  input logic       conv_dn,
  input logic       mod_up,
  input logic       mod_dn,
  input logic [2:0] cp_setting,
  input logic [1:0] cp_code,
  input logic       lock,
  input logic       conv_locked,
  input logic       mod_locked,
  input logic       conv_fr,
  input logic       mod_fr
);

  AST_CONV_PFD_EXCL: assert property (@(posedge clk) disable iff (rst) !(conv_up && conv_dn)); // R4
  AST_MOD_PFD_EXCL: assert property (@(posedge clk) disable iff (rst) !(mod_up && mod_dn)); // R4
  AST_LOCK_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst) lock |-> $past(conv_locked && mod_locked)); // R6
  AST_CONV_LOCK_AT_PERIOD: assert property (@(posedge clk) disable iff (rst) $rose(conv_locked) |-> $past(conv_fr)); // R5
  AST_MOD_LOCK_AT_PERIOD: assert property (@(posedge clk) disable iff (rst) $rose(mod_locked) |-> $past(mod_fr)); // R5
  AST_CP_SEL0_LOCKED: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && $past(cp_setting) == 3'b000 && $past(conv_locked)) |-> cp_code == 2'b01); // R7
  AST_CP_SEL1_UNLOCKED: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && $past(cp_setting) == 3'b001 && !$past(conv_locked)) |-> cp_code == 2'b01); // R8
  AST_CP_FORCED_HIGH: assert property (@(posedge clk) disable iff (rst) (!$past(rst) && $past(cp_setting) == 3'b100) |-> cp_code == 2'b10); // R9

endmodule

bind pll_synth_core pll_synth_core_chk u_chk (
  .clk(clk), .rst(rst),
  .conv_up(conv_up), .conv_dn(conv_dn), .mod_up(mod_up), .mod_dn(mod_dn),
  .cp_setting(cp_setting), .cp_code(cp_code), .lock(lock),
  .conv_locked(conv_locked), .mod_locked(mod_locked),
  .conv_fr(conv_fr), .mod_fr(mod_fr)
);

// File: tb/sim_pll_synth_core.sv
module sim_pll_synth_core;

  localparam int TH = 6, LP = 16, PRE = 2, PS = 4, MFB = 20;
  localparam int RMIN = 4, RMAX = 16, NMIN = 10, NMAX = 40;

  logic clk = 1'b0, rst = 1'b1;
  logic ref_ev = 1'b0, conv_vco_ev = 1'b0, mod_vco_ev = 1'b0;
  logic [7:0]  conv_ref_ratio = 8'd4;
  logic [11:0] conv_fb_ratio = 12'd10;
  logic [1:0]  mod_ref_sel = 2'b11;
  logic [2:0]  cp_setting = 3'b000;
  logic conv_up, conv_dn, mod_up, mod_dn, lock;
  logic [1:0] cp_code;

  int n_chk = 0, n_err = 0;
  int tr = 5, tc = 1, tm = 1, k = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pll_synth_core #(
    .REF_PREDIV(PRE), .FB_PRESCALE(PS), .MOD_FB_RATIO(MFB),
    .CONV_REF_MIN(RMIN), .CONV_REF_MAX(RMAX), .CONV_FB_MIN(NMIN), .CONV_FB_MAX(NMAX),
    .PW_THRESH(TH), .LOCK_PERIODS(LP)
  ) u0 (
    .clk(clk), .rst(rst), .ref_ev(ref_ev), .conv_vco_ev(conv_vco_ev), .mod_vco_ev(mod_vco_ev),
    .conv_ref_ratio(conv_ref_ratio), .conv_fb_ratio(conv_fb_ratio),
    .mod_ref_sel(mod_ref_sel), .cp_setting(cp_setting),
    .conv_up(conv_up), .conv_dn(conv_dn), .mod_up(mod_up), .mod_dn(mod_dn),
    .cp_code(cp_code), .lock(lock)
  );

  function automatic int clampi(int v, int lo, int hi);
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  function automatic int sel_ratio(logic [1:0] s); // R3 mapping
    return (s == 2'b11) ? 4 : (s == 2'b10) ? 8 : 16;
  endfunction

  function automatic int cp_exp(logic [2:0] s, bit lk); // 0 low, 1 medium, 2 high
    case (s)
      3'b000:  return lk ? 1 : 2;
      3'b001:  return lk ? 0 : 1;
      3'b010:  return 0;
      3'b011:  return 1;
      3'b100:  return 2;
      default: return 0;
    endcase
  endfunction

  // Behavioural model: event counters per stage, index 0 converter, 1 modulator
  int  pre_c, ps_c, cr_c, cf_c, mr_c, mf_c;
  bit  pre_o, ps_o;
  bit  fr[2], fv[2], up_m[2], dn_m[2], bad_m[2], lk_m[2];
  int  wid_m[2], good_m[2];
  bit  lock_m;
  int  cp_m;
  bit  act, ov;

  always @(posedge clk) begin
    if (rst) begin
      pre_c <= 0; ps_c <= 0; cr_c <= 0; cf_c <= 0; mr_c <= 0; mf_c <= 0;
      pre_o <= 0; ps_o <= 0; lock_m <= 0; cp_m <= 0;
      for (int i = 0; i < 2; i++) begin
        fr[i] <= 0; fv[i] <= 0; up_m[i] <= 0; dn_m[i] <= 0;
        bad_m[i] <= 0; lk_m[i] <= 0; wid_m[i] <= 0; good_m[i] <= 0;
      end
    end else begin
      pre_o <= 0;
      if (ref_ev) begin if (pre_c >= PRE - 1) begin pre_c <= 0; pre_o <= 1; end else pre_c <= pre_c + 1; end
      ps_o <= 0;
      if (conv_vco_ev) begin if (ps_c >= PS - 1) begin ps_c <= 0; ps_o <= 1; end else ps_c <= ps_c + 1; end
      fr[0] <= 0;
      if (pre_o) begin if (cr_c >= clampi(conv_ref_ratio, RMIN, RMAX) - 1) begin cr_c <= 0; fr[0] <= 1; end else cr_c <= cr_c + 1; end
      fv[0] <= 0;
      if (ps_o) begin if (cf_c >= clampi(conv_fb_ratio, NMIN, NMAX) - 1) begin cf_c <= 0; fv[0] <= 1; end else cf_c <= cf_c + 1; end
      fr[1] <= 0;
      if (ref_ev) begin if (mr_c >= sel_ratio(mod_ref_sel) - 1) begin mr_c <= 0; fr[1] <= 1; end else mr_c <= mr_c + 1; end
      fv[1] <= 0;
      if (mod_vco_ev) begin if (mf_c >= MFB - 1) begin mf_c <= 0; fv[1] <= 1; end else mf_c <= mf_c + 1; end
      for (int i = 0; i < 2; i++) begin
        up_m[i] <= (up_m[i] | fr[i]) & ~(dn_m[i] | fv[i]);
        dn_m[i] <= (dn_m[i] | fv[i]) & ~(up_m[i] | fr[i]);
        act = up_m[i] | dn_m[i];
        wid_m[i] <= act ? ((wid_m[i] >= TH) ? TH : wid_m[i] + 1) : 0;
        ov = act && (wid_m[i] >= TH - 1);
        if (ov) begin
          lk_m[i] <= 0; good_m[i] <= 0; bad_m[i] <= 1;
        end else if (fr[i]) begin
          if (bad_m[i]) begin bad_m[i] <= 0; good_m[i] <= 0; end
          else if (good_m[i] >= LP - 1) lk_m[i] <= 1;
          else good_m[i] <= good_m[i] + 1;
        end
      end
      lock_m <= lk_m[0] & lk_m[1];
      cp_m   <= cp_exp(cp_setting, lk_m[0]);
    end
  end

  task automatic chk(input string tag, input int act_v, input int exp_v);
    n_chk++;
    if (act_v != exp_v) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  task automatic run(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      chk("R1 R2 R4 conv_up/dn", {conv_up, conv_dn}, {up_m[0], dn_m[0]});
      chk("R3 R4 mod_up/dn", {mod_up, mod_dn}, {up_m[1], dn_m[1]});
      chk("R5 R6 lock", lock, lock_m);
      chk("R7 R8 R9 cp_code", cp_code, cp_m);
      ref_ev      = (k % tr == 0);
      conv_vco_ev = (k % tc == 0);
      mod_vco_ev  = (k % tm == 0);
      k++;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; ref_ev = 0; conv_vco_ev = 0; mod_vco_ev = 0; k = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    chk("R10 up/dn in reset", {conv_up, conv_dn, mod_up, mod_dn}, 0);
    chk("R10 lock in reset", lock, 0);
    chk("R10 cp_code in reset", cp_code, 0);

    // Both loops at matching rates: lock acquired
    tr = 5; tc = 1; tm = 1;
    do_reset();
    run(1500);
    chk("R6 lock with both loops tracking", lock, 1);
    chk("R7 setting 000 locked gives medium", cp_code, 1);

    // Setting table while converter is locked
    cp_setting = 3'b001; run(2); chk("R8 setting 001 locked gives low", cp_code, 0);
    cp_setting = 3'b010; run(2); chk("R9 setting 010 gives low", cp_code, 0);
    cp_setting = 3'b011; run(2); chk("R9 setting 011 gives medium", cp_code, 1);
    cp_setting = 3'b100; run(2); chk("R9 setting 100 gives high", cp_code, 2);
    cp_setting = 3'b110; run(2); chk("R9 reserved setting 110 gives low", cp_code, 0);
    cp_setting = 3'b000; run(2);

    // Modulator feedback at half rate: combined lock falls, converter stays locked
    tm = 2;
    run(300);
    chk("R6 lock low when modulator loses lock", lock, 0);
    chk("R7 converter still locked gives medium", cp_code, 1);

    // Feedback ratio below range behaves as minimum
    tm = 1; conv_fb_ratio = 12'd5;
    do_reset();
    run(1500);
    chk("R2 clamped feedback ratio still locks", lock, 1);

    // Reference ratio above range clamps to maximum: converter out of lock
    conv_ref_ratio = 8'd200;
    run(600);
    chk("R1 R5 oversized reference ratio unlocks", lock, 0);
    chk("R7 unlocked setting 000 gives high", cp_code, 2);
    cp_setting = 3'b001; run(2);
    chk("R8 setting 001 unlocked gives medium", cp_code, 1);
    cp_setting = 3'b000; conv_ref_ratio = 8'd4; conv_fb_ratio = 12'd10;

    // Select 10 gives 8, modulator feedback every 2 events
    mod_ref_sel = 2'b10; tm = 2;
    do_reset();
    run(1500);
    chk("R3 select 10 ratio 8 locks", lock, 1);

    // Select 00 treated as 16, modulator feedback every 4 events
    mod_ref_sel = 2'b00; tm = 4;
    do_reset();
    run(2000);
    chk("R3 select 00 ratio 16 locks", lock, 1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule